// File: doc/BRIEF.md
# Windowed Sync Pulse Rate Meter

The block measures how many sync pulses arrive on one of two sync inputs within a fixed measurement window of 2^13 enabled reference clock cycles. Both inputs enter the block asynchronously. Each one is synchronized through two flops, and its rising edges are detected separately. A source-select bit chooses which input's edges reach a 5-bit counter. The counter saturates at 31. On the last cycle of each window, the counter value is copied into a 5-bit latch and the counter starts a new window.

Software reaches the block through one 8-bit register on a plain chip-select/read/write port:
- Reads are combinational. No read or write is ever stalled, so the port has no back-pressure.
- The latch value appears in the low five bits of the register.
- Bit 5 holds the source select.
- The two top bits always read as zero.

An enable pin from a separate mode control turns the whole measurement on or off.

Top module: `sync_rate_meter`

## Requirements
- R1: While enabled, the latch is rewritten exactly once per window of 2^13 (`1 << WIN_LOG2`) enabled clock cycles. The write happens on the last cycle of the window. Between those cycles the latch holds its value.
- R2: Each rising edge of the selected input, after two-flop synchronization, adds one to the count once. This holds however long the input then stays high.
- R3: When more than 31 edges arrive in a window, the latch receives 31 (0x1F).
- R4: An edge that reaches the counter in the same cycle that closes a window is not part of the closing window's latched value. It is counted as the first edge of the new window.
- R5: With `cs_i` and `rd_i` both high, `rdata_o` shows the register in the same cycle: bits 4:0 are the latch, bit 5 is the source select, and bits 7:6 are 0. At all other times `rdata_o` is 0.
- R6: A write (`cs_i` and `wr_i` high) changes only bit 5, taken from `wdata_i[5]`. The latch and bits 7:6 are unaffected. Without `cs_i`, a write has no effect.
- R7: After reset, the source select is 0 and the latch is 0, so the register reads 0x00.
- R8: Source select 0 counts the horizontal sync input `hsync_i`; 1 counts the composite sync input `csync_i`. Pulses on the input that is not selected are not counted.
- R9: While `en_i` is low, the window timer and the counter are held at zero, and the latch keeps its last value. The first full window after `en_i` rises again counts only the edges inside that window.
- R10: A new source select applies from the cycle after the write. The window in progress is not restarted, so its count can include edges from both inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Measurement enable from the mode control |
| hsync_i | input | 1 | Horizontal sync input (asynchronous) |
| csync_i | input | 1 | Composite sync input (asynchronous) |
| cs_i | input | 1 | Register chip select |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |

## Verification
The window close and a counted edge can fall in the same cycle. The bench provokes this by raising a short horizontal sync pulse three cycles before the window ends, so its synchronized edge reaches the counter exactly on the closing cycle. The bench then judges two results:
- The latch for the closing window must leave the pulse out.
- The following window's latched value must be one higher than the pulses placed inside that window.

A second collision, a source-select write in the middle of a window, is judged by the mixed count that window produces.

// File: rtl/srm_pkg.sv
package srm_pkg;
  typedef enum logic {
    SRC_HSYNC = 1'b0,
    SRC_CSYNC = 1'b1
  } src_e;

  function automatic logic [4:0] sat_inc5(input logic [4:0] v);
    return (v == 5'h1F) ? v : v + 5'd1;
  endfunction
endpackage

// File: rtl/srm_edge_sync.sv
module srm_edge_sync #(
  parameter int N_IN = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] level_i,
  output logic [N_IN-1:0] rise_o
);
  for (genvar g = 0; g < N_IN; g++) begin : g_lane
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= level_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign rise_o[g] = sync_q & ~prev_q;

    // R2
    one_rise_per_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/srm_window_timer.sv
module srm_window_timer #(
  parameter int WIN_LOG2 = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  logic [WIN_LOG2-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tmr_q <= '0;
    else if (!en_i) tmr_q <= '0;
    else            tmr_q <= tmr_q + 1'b1;
  end

  assign tick_o = en_i && (&tmr_q);

  // R9
  restart_from_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> (tmr_q == '0));

  // R1
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/srm_sat_counter.sv
module srm_sat_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] latch_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] latch_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)                            cnt_d = '0;
    else if (tick_i)                      cnt_d = pulse_i ? CNT_W'(1) : '0;
    else if (pulse_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      latch_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (tick_i) latch_q <= cnt_q;
    end
  end

  assign latch_o = latch_q;

  // R3
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R1
  latch_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(latch_q));

  // R2
  count_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/sync_rate_meter.sv
module sync_rate_meter #(
  parameter int WIN_LOG2 = 13,
  parameter int CNT_W    = 5,
  parameter int DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              hsync_i,
  input  logic              csync_i,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  import srm_pkg::*;

  localparam int SEL_BIT = CNT_W;
  localparam int PAD_W   = DATA_W - CNT_W - 1;

  src_e             src_sel_q;
  logic [1:0]       rise;
  logic             tick;
  logic             pulse;
  logic [CNT_W-1:0] latch;
  logic             unused_wbits;

  srm_edge_sync #(.N_IN(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i ({csync_i, hsync_i}),
    .rise_o  (rise)
  );

  srm_window_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_o (tick)
  );

  assign pulse = (src_sel_q == SRC_CSYNC) ? rise[1] : rise[0];

  srm_sat_counter #(.CNT_W(CNT_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .tick_i  (tick),
    .pulse_i (pulse),
    .latch_o (latch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          src_sel_q <= SRC_HSYNC;
    else if (cs_i && wr_i) src_sel_q <= src_e'(wdata_i[SEL_BIT]);
  end

  assign unused_wbits = ^{wdata_i[DATA_W-1:SEL_BIT+1], wdata_i[SEL_BIT-1:0]};

  assign rdata_o = (cs_i && rd_i) ? {{PAD_W{1'b0}}, src_sel_q, latch} : '0;

  // R6
  sel_write_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && wr_i) |=> $stable(src_sel_q));

  // R10
  sel_takes_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i) |=> (src_sel_q == src_e'($past(wdata_i[SEL_BIT]))));
endmodule

// File: tb/sync_rate_meter_tb_top.sv
module sync_rate_meter_tb_top;
  localparam int WIN = 8192;
  localparam int NV  = 7;
  localparam int V_SEL [NV] = '{0, 1, 0, 0, 1, 1, 0};
  localparam int V_NH  [NV] = '{3, 2, 31, 40, 0, 33, 0};
  localparam int V_NC  [NV] = '{5, 7, 0, 3, 32, 0, 9};

  logic clk = 0, rst_n = 0, en = 0, hs = 0, cs_in = 0;
  logic cs = 0, rd = 0, wr = 0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  bit cur_sel = 0;
  int pending = 0, carry = 0;
  string ptag = "R7";

  sync_rate_meter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .hsync_i(hs), .csync_i(cs_in),
    .cs_i(cs), .rd_i(rd), .wr_i(wr), .wdata_i(wd), .rdata_o(rdata)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_now(output logic [7:0] v);
    cs = 1; rd = 1; #1; v = rdata; cs = 0; rd = 0;
  endtask

  function automatic logic [7:0] reg_exp();
    int p = (pending > 31) ? 31 : pending;
    return {2'b00, cur_sel, 5'(p)};
  endfunction

  task automatic run_window(input int nh, input int nc, input bit sel_a,
                            input bit flip, input bit late, input string tag);
    bit sel_b = flip ? ~sel_a : sel_a;
    logic [7:0] v;
    int e;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      en = 1; cs = 0; wr = 0; rd = 0;
      if (i == 0 || i == 4096) begin
        rd_now(v);
        chk({ptag, " window result"}, v, reg_exp());
      end
      if (i == 8) begin
        cs = 1; wr = 1; wd = {~sel_a, ~sel_a, sel_a, 5'b10101}; cur_sel = sel_a;
      end
      if (flip && i == 4000) begin
        cs = 1; wr = 1; wd = {2'b00, sel_b, 5'b01010}; cur_sel = sel_b;
      end
      hs = (i >= 16 && i < 16 + 4*nh && ((i-16) % 4) < 2) || (late && (i == 8189 || i == 8190));
      cs_in = (i >= 4400 && i < 4400 + 4*nc && ((i-4400) % 4) < 2);
    end
    e = carry + (sel_a == 0 ? nh : 0) + (sel_b == 1 ? nc : 0);
    pending = e;
    carry = (late && sel_b == 0) ? 1 : 0;
    ptag = tag;
  endtask

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rd_now(v); chk("R7 reset value", v, 8'h00);
    cs = 1; rd = 0; #1; chk("R5 no read strobe", rdata, 8'h00); cs = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk); rd_now(v); chk("R7 after release", v, 8'h00);
    cs = 0; wr = 1; wd = 8'hFF;
    @(negedge clk); wr = 0; rd_now(v); chk("R6 write without cs", v, 8'h00);
    cs = 1; wr = 1; wd = 8'hFF;
    @(negedge clk); cs = 0; wr = 0; rd_now(v); chk("R5 R6 only bit5 written", v, 8'h20);
    cs = 1; wr = 1; wd = 8'hDF;
    @(negedge clk); cs = 0; wr = 0; rd_now(v); chk("R6 bit5 cleared", v, 8'h00);
    cur_sel = 0;

    for (int k = 0; k < NV; k++)
      run_window(V_NH[k], V_NC[k], V_SEL[k][0], 0, 0, "R1 R2 R3 R8");

    run_window(5, 4, 0, 1, 0, "R10 mixed sources");
    run_window(2, 0, 0, 0, 1, "R4 boundary edge excluded");
    run_window(3, 0, 0, 0, 0, "R4 boundary edge carried");

    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      en = 0; cs = 0; wr = 0; rd = 0;
      hs = (i >= 20 && i < 100 && (i % 4) < 2);
      cs_in = hs;
      if (i == 150) begin
        rd_now(v); chk("R9 latch kept while disabled", v, reg_exp());
      end
    end
    hs = 0; cs_in = 0;
    run_window(6, 2, 1, 0, 0, "R9 fresh window after enable");

    @(negedge clk); rd_now(v); chk({ptag, " final"}, v, reg_exp());

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule